// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block caches virtual-to-physical page translations for a processor pipeline. It holds a small number of entries, any of which may carry any translation. A lookup presents a virtual page number and the current address space identifier; every stored entry is compared at once, and the frame number and protection bits of the matching entry come back combinationally in the same cycle. Because each entry is tagged with the address space it belongs to, a context change needs no invalidation: entries of other spaces simply fail to match.

A fill port installs a translation that the page-table walker outside this block has fetched. A fill reuses the slot that already holds the same page and space, else takes a free slot, else evicts the least recently used entry. A flush port removes either every entry or only those of one address space. Each hit marks its entry referenced, a write-type hit also marks it modified, and both hits and fills count as uses for replacement.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: A lookup hits only when a valid entry has both the same page number and the same space identifier; on a hit `lk_pfn` and `lk_prot` show that entry's frame and protection in the same cycle, with no clock edge in between.
- R3: `lk_miss` is high exactly when `lk_valid` is high and no entry matches; a missing lookup changes no stored entry, flag or replacement order.
- R4: A hit sets the entry's referenced flag at the next edge; `lk_ref` and `lk_mod` show the flags as stored before that update.
- R5: A hit with `lk_write` high also sets the entry's modified flag.
- R6: A fill whose page number and space identifier equal a valid entry's overwrites that entry in place; every fill stores the entry valid with referenced and modified flags cleared.
- R7: While any entry is invalid, a fill uses an invalid entry and displaces no valid translation.
- R8: When all entries are valid, a fill with a new key replaces the entry whose last hit or fill lies furthest in the past.
- R9: A flush with `flush_all` high invalidates every entry.
- R10: A flush with `flush_all` low invalidates only entries whose space identifier equals `flush_asid`.
- R11: A flush takes precedence over a fill in the same cycle, which is then dropped; a fill takes precedence over a hit's flag and use update in the same cycle, which is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_asid | input | 4 | Address space identifier of the lookup |
| lk_write | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | Matching entry found |
| lk_miss | output | 1 | Lookup requested and nothing matched |
| lk_pfn | output | 20 | Frame number of the matching entry (zero on miss) |
| lk_prot | output | 2 | Protection bits of the matching entry (zero on miss) |
| lk_ref | output | 1 | Stored referenced flag of the matching entry |
| lk_mod | output | 1 | Stored modified flag of the matching entry |
| fill_valid | input | 1 | Install a translation this cycle |
| fill_vpn | input | 20 | Page number of the new translation |
| fill_asid | input | 4 | Space identifier of the new translation |
| fill_pfn | input | 20 | Frame number of the new translation |
| fill_prot | input | 2 | Protection bits of the new translation |
| flush_valid | input | 1 | Invalidate entries this cycle |
| flush_all | input | 1 | 1: invalidate all; 0: only entries of `flush_asid` |
| flush_asid | input | 4 | Space identifier selected for a partial flush |

## Verification
The bench aims at replacement order: it fills the array in sequence, re-touches the oldest entry, and checks that the next new fill evicts the second-oldest instead; a design that ignored hits when ageing would evict the touched entry. It refills an existing key and then fills the remaining slots, so a design that allocated a duplicate slot would lose one translation. Partial flushes followed by fills show whether free slots are preferred over eviction, and a flush paired with a fill in the same cycle catches a design that let the fill survive. Flag tests read the referenced and modified outputs across consecutive hits to catch updates applied too early, on misses, or to the wrong entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VPN_W   = 20;
    parameter int ASID_W  = 4;
    parameter int PFN_W   = 20;
    parameter int PROT_W  = 2;
    parameter int ENTRIES = 16;
    localparam int IDX_W  = $clog2(ENTRIES);

    typedef struct packed {
        logic              valid;
        logic              ref_b;
        logic              mod_b;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic [PROT_W-1:0] prot;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match
    import tlb_pkg::*;
(
    input  tlb_entry_t [ENTRIES-1:0] tab,
    input  logic                     key_en,
    input  logic [VPN_W-1:0]         key_vpn,
    input  logic [ASID_W-1:0]        key_asid,
    output logic [ENTRIES-1:0]       hits
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hits[e] = key_en && tab[e].valid &&
                         (tab[e].vpn == key_vpn) && (tab[e].asid == key_asid);
    end
endmodule

// File: rtl/tlb_lru_ages.sv
module tlb_lru_ages
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] lru_idx
);
    typedef struct packed {
        logic [ENTRIES-1:0][IDX_W-1:0] age;
    } lru_state_t;

    lru_state_t state_d, state_q;
    logic [ENTRIES-1:0] oldest;

    always_comb begin
        state_d = state_q;
        if (touch_en) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (IDX_W'(j) == touch_idx)
                    state_d.age[j] = '0;
                else if (state_q.age[j] < state_q.age[touch_idx])
                    state_d.age[j] = state_q.age[j] + 1'b1;
            end
        end
    end

    always_comb begin
        lru_idx = '0;
        for (int j = ENTRIES - 1; j >= 0; j--) begin
            oldest[j] = (state_q.age[j] == IDX_W'(ENTRIES - 1));
            if (oldest[j]) lru_idx = IDX_W'(j);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < ENTRIES; j++) state_q.age[j] <= IDX_W'(j);
        end else begin
            state_q <= state_d;
        end
    end

    // R8
    lru_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest));

    for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
        // R8
        touch_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (touch_en && touch_idx == IDX_W'(e)) |=> (state_q.age[e] == '0));
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [PROT_W-1:0] lk_prot,
    output logic              lk_ref,
    output logic              lk_mod,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PROT_W-1:0] fill_prot,
    input  logic              flush_valid,
    input  logic              flush_all,
    input  logic [ASID_W-1:0] flush_asid
);
    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] tab;
    } tlb_state_t;

    tlb_state_t state_d, state_q;

    logic [ENTRIES-1:0] lk_hits, fl_hits, free_vec;
    logic [IDX_W-1:0]   hit_idx, same_idx, free_idx, lru_idx, fill_idx, touch_idx;
    logic               touch_en;
    tlb_entry_t         hit_ent;

    tlb_cam_match u_lk_match (
        .tab(state_q.tab), .key_en(lk_valid), .key_vpn(lk_vpn),
        .key_asid(lk_asid), .hits(lk_hits)
    );

    tlb_cam_match u_fill_match (
        .tab(state_q.tab), .key_en(fill_valid), .key_vpn(fill_vpn),
        .key_asid(fill_asid), .hits(fl_hits)
    );

    tlb_lru_ages u_lru (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en),
        .touch_idx(touch_idx), .lru_idx(lru_idx)
    );

    // index encoders: matching slots are unique, free slot picks the lowest
    always_comb begin
        hit_idx  = '0;
        same_idx = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            free_vec[i] = !state_q.tab[i].valid;
            if (lk_hits[i])  hit_idx  = IDX_W'(i);
            if (fl_hits[i])  same_idx = IDX_W'(i);
            if (free_vec[i]) free_idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (|fl_hits)       fill_idx = same_idx;
        else if (|free_vec) fill_idx = free_idx;
        else                fill_idx = lru_idx;
    end

    // lookup result
    always_comb begin
        hit_ent = state_q.tab[hit_idx];
        lk_hit  = |lk_hits;
        lk_miss = lk_valid && !lk_hit;
        lk_pfn  = lk_hit ? hit_ent.pfn  : '0;
        lk_prot = lk_hit ? hit_ent.prot : '0;
        lk_ref  = lk_hit && hit_ent.ref_b;
        lk_mod  = lk_hit && hit_ent.mod_b;
    end

    // next state: flush, then fill, then hit update
    always_comb begin
        state_d   = state_q;
        touch_en  = 1'b0;
        touch_idx = '0;
        if (flush_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush_all || state_q.tab[i].asid == flush_asid)
                    state_d.tab[i].valid = 1'b0;
            end
        end else if (fill_valid) begin
            state_d.tab[fill_idx].valid = 1'b1;
            state_d.tab[fill_idx].ref_b = 1'b0;
            state_d.tab[fill_idx].mod_b = 1'b0;
            state_d.tab[fill_idx].asid  = fill_asid;
            state_d.tab[fill_idx].vpn   = fill_vpn;
            state_d.tab[fill_idx].pfn   = fill_pfn;
            state_d.tab[fill_idx].prot  = fill_prot;
            touch_en  = 1'b1;
            touch_idx = fill_idx;
        end else if (lk_hit) begin
            state_d.tab[hit_idx].ref_b = 1'b1;
            if (lk_write) state_d.tab[hit_idx].mod_b = 1'b1;
            touch_en  = 1'b1;
            touch_idx = hit_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R2
    lk_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hits));

    // R3
    miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    // R3
    miss_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_miss && !fill_valid && !flush_valid) |=> $stable(state_q));

    // R9
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && flush_all) |=> (free_vec == '1));

    for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
        // R4
        ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_hits[e] && !fill_valid && !flush_valid) |=> state_q.tab[e].ref_b);
        // R10
        flush_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_valid && !flush_all && state_q.tab[e].asid != flush_asid)
            |=> $stable(state_q.tab[e]));
    end
endmodule

// File: tb/sim_asid_tlb.sv
`timescale 1ns/1ps
module sim_asid_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_write = 0;
    logic [19:0] lk_vpn = '0;
    logic [3:0]  lk_asid = '0;
    logic        lk_hit, lk_miss, lk_ref, lk_mod;
    logic [19:0] lk_pfn;
    logic [1:0]  lk_prot;
    logic        fill_valid = 0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic [3:0]  fill_asid = '0;
    logic [1:0]  fill_prot = '0;
    logic        flush_valid = 0, flush_all = 0;
    logic [3:0]  flush_asid = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    asid_tlb u0 (.*);

    // captured lookup results
    logic        r_hit, r_miss, r_ref, r_mod;
    logic [19:0] r_pfn;
    logic [1:0]  r_prot;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        lk_valid = 0; lk_write = 0; fill_valid = 0; flush_valid = 0; flush_all = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); idle(); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic look(input logic [19:0] v, input logic [3:0] a, input logic wr);
        @(negedge clk);
        lk_valid = 1; lk_vpn = v; lk_asid = a; lk_write = wr;
        #1;
        r_hit = lk_hit; r_miss = lk_miss; r_pfn = lk_pfn; r_prot = lk_prot;
        r_ref = lk_ref; r_mod = lk_mod;
        @(negedge clk); idle();
    endtask

    task automatic fill(input logic [19:0] v, input logic [3:0] a,
                        input logic [19:0] p, input logic [1:0] pr);
        @(negedge clk);
        fill_valid = 1; fill_vpn = v; fill_asid = a; fill_pfn = p; fill_prot = pr;
        @(negedge clk); idle();
    endtask

    task automatic flush(input logic all, input logic [3:0] a);
        @(negedge clk);
        flush_valid = 1; flush_all = all; flush_asid = a;
        @(negedge clk); idle();
    endtask

    task automatic t_reset();
        do_reset();
        look(20'h00005, 4'd1, 0);
        chk("R1 hit after reset", r_hit, 0);
        chk("R3 miss after reset", r_miss, 1);
        @(negedge clk); #1;
        chk("R3 no miss when idle", lk_miss, 0);
    endtask

    task automatic t_basic();
        do_reset();
        fill(20'h12345, 4'd3, 20'hABCDE, 2'd2);
        look(20'h12345, 4'd3, 0);
        chk("R2 hit", r_hit, 1);
        chk("R2 pfn", r_pfn, 20'hABCDE);
        chk("R2 prot", r_prot, 2'd2);
        look(20'h12345, 4'd4, 0);
        chk("R2 asid mismatch misses", r_hit, 0);
        look(20'h12344, 4'd3, 0);
        chk("R3 vpn mismatch miss", r_miss, 1);
    endtask

    task automatic t_flags();
        do_reset();
        fill(20'h00100, 4'd2, 20'h00777, 2'd1);
        fill(20'h00200, 4'd2, 20'h00888, 2'd0);
        look(20'h00100, 4'd2, 0);
        chk("R4 ref clear on first hit", r_ref, 0);
        look(20'h00100, 4'd2, 0);
        chk("R4 ref set after hit", r_ref, 1);
        chk("R5 mod clear after read", r_mod, 0);
        look(20'h00100, 4'd2, 1);
        chk("R5 mod before write update", r_mod, 0);
        look(20'h00100, 4'd2, 0);
        chk("R5 mod set after write hit", r_mod, 1);
        look(20'h00300, 4'd2, 1);
        look(20'h00200, 4'd9, 1);
        look(20'h00200, 4'd2, 0);
        chk("R3 misses left ref untouched", r_ref, 0);
        chk("R3 misses left mod untouched", r_mod, 0);
    endtask

    task automatic t_overwrite();
        do_reset();
        fill(20'h0AAAA, 4'd5, 20'h11111, 2'd1);
        look(20'h0AAAA, 4'd5, 1);
        fill(20'h0AAAA, 4'd5, 20'h22222, 2'd3);
        look(20'h0AAAA, 4'd5, 0);
        chk("R6 overwritten pfn", r_pfn, 20'h22222);
        chk("R6 overwritten prot", r_prot, 2'd3);
        chk("R6 ref cleared by fill", r_ref, 0);
        chk("R6 mod cleared by fill", r_mod, 0);
        for (int i = 1; i < 16; i++) fill(20'(i), 4'd5, 20'(i + 16'h100), 2'd0);
        look(20'h0AAAA, 4'd5, 0);
        chk("R6 no duplicate slot, key kept", r_hit, 1);
        for (int i = 1; i < 16; i++) begin
            look(20'(i), 4'd5, 0);
            chk("R6 other fills kept", r_hit, 1);
        end
    endtask

    task automatic t_lru();
        do_reset();
        for (int i = 0; i < 16; i++) fill(20'(16'h400 + i), 4'd1, 20'(i), 2'd0);
        look(20'h00400, 4'd1, 0);
        fill(20'h00500, 4'd1, 20'h0BBBB, 2'd0);
        look(20'h00401, 4'd1, 0);
        chk("R8 oldest evicted", r_hit, 0);
        look(20'h00400, 4'd1, 0);
        chk("R8 touched entry kept", r_hit, 1);
        look(20'h00500, 4'd1, 0);
        chk("R8 new entry present", r_pfn, 20'h0BBBB);
        fill(20'h00501, 4'd1, 20'h0CCCC, 2'd0);
        look(20'h00402, 4'd1, 0);
        chk("R8 next oldest evicted", r_hit, 0);
        look(20'h00403, 4'd1, 0);
        chk("R8 younger kept", r_hit, 1);
    endtask

    task automatic t_flush();
        do_reset();
        for (int i = 0; i < 16; i++) fill(20'(16'h800 + i), 4'(i % 2 + 1), 20'(i), 2'd0);
        flush(0, 4'd1);
        for (int i = 0; i < 16; i++) begin
            look(20'(16'h800 + i), 4'(i % 2 + 1), 0);
            chk("R10 partial flush", r_hit, (i % 2 == 0) ? 0 : 1);
        end
        for (int i = 0; i < 8; i++) fill(20'(16'h900 + i), 4'd3, 20'(16'h50 + i), 2'd0);
        for (int i = 0; i < 8; i++) begin
            look(20'(16'h801 + 2 * i), 4'd2, 0);
            chk("R7 valid entries not displaced", r_hit, 1);
            look(20'(16'h900 + i), 4'd3, 0);
            chk("R7 fill into free slot", r_pfn, 20'(16'h50 + i));
        end
        flush(1, 4'd0);
        for (int i = 0; i < 8; i++) begin
            look(20'(16'h900 + i), 4'd3, 0);
            chk("R9 flush all", r_hit, 0);
            look(20'(16'h801 + 2 * i), 4'd2, 0);
            chk("R9 flush all", r_hit, 0);
        end
    endtask

    task automatic t_prio();
        do_reset();
        fill(20'h00042, 4'd7, 20'h00042, 2'd0);
        @(negedge clk);
        flush_valid = 1; flush_all = 1;
        fill_valid = 1; fill_vpn = 20'h00043; fill_asid = 4'd7; fill_pfn = 20'h1; fill_prot = 2'd0;
        @(negedge clk); idle();
        look(20'h00042, 4'd7, 0);
        chk("R11 flush applied", r_hit, 0);
        look(20'h00043, 4'd7, 0);
        chk("R11 fill dropped under flush", r_hit, 0);
        fill(20'h00044, 4'd7, 20'h00044, 2'd0);
        @(negedge clk);
        lk_valid = 1; lk_vpn = 20'h00044; lk_asid = 4'd7; lk_write = 1;
        fill_valid = 1; fill_vpn = 20'h00045; fill_asid = 4'd7; fill_pfn = 20'h2; fill_prot = 2'd0;
        @(negedge clk); idle();
        look(20'h00044, 4'd7, 0);
        chk("R11 hit ref dropped under fill", r_ref, 0);
        chk("R11 hit mod dropped under fill", r_mod, 0);
        look(20'h00045, 4'd7, 0);
        chk("R11 fill done", r_hit, 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_flags();
        t_overwrite();
        t_lru();
        t_flush();
        t_prio();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule